// File: doc/BRIEF.md
# Ethernet Socket Bring-Up Supervisor

This block takes an external Ethernet controller, reached through a simple one-at-a-time register access port, from power-up into a TCP socket that listens for a connection. It then keeps the socket in that state. First it holds the controller's active-low reset pin low, releases it, and waits for the controller to settle. It then writes the station identity (hardware address, IP address, subnet mask, gateway) and the socket buffer split. Next it configures socket 0 for TCP on a fixed port and opens it. It polls the socket status until the socket is initialised, commands listen, and polls again until the socket listens.

After bring-up the block reads the socket status at a fixed interval. An established connection raises `link_ready`, and a listening socket lowers it. Any other code is read a second time straight away. If the second read is still unexpected, the block drops `link_ready` and runs the whole reset and configuration sequence again.

A separate serial engine turns each request into wire traffic. It answers every request with a one-cycle `req_done`, and for a read it puts the status byte on `req_rdata` in that same cycle. All register addresses, codes, identity values and timings are parameters.

Top module: `eth_link_keeper`

## Requirements
- R1: Controller reset timing.
  - After the block's own reset is released, `ctrl_rst_n` stays low for exactly RST_LOW_CYC = CLK_HZ/20 cycles.
  - After a recovery, `ctrl_rst_n` also stays low for exactly RST_LOW_CYC cycles.
  - No request is issued while `ctrl_rst_n` is low.
- R2: The first request after `ctrl_rst_n` rises appears SETTLE_CYC+1 cycles after the rise, where SETTLE_CYC = CLK_HZ/200.
- R3: Writes 1 to 18 program the station identity, in this order:
  - Hardware address: 6 bytes, most significant byte first, to MAC_REG+0..5.
  - IP address: 4 bytes to IP_REG+0..3.
  - Subnet mask: 4 bytes to MASK_REG+0..3.
  - Gateway: 4 bytes to GW_REG+0..3.
- R4: Write 19 puts MEM_SPLIT (default 0x0A) into RXMEM_REG. Write 20 puts MEM_SPLIT into TXMEM_REG. Write 21 puts SOCK_MODE_TCP (default 0x01) into SMODE_REG.
- R5: Write 22 puts the high byte of LISTEN_PORT (default 5000) into PORT_REG. Write 23 puts the low byte into PORT_REG+1. Write 24 puts CMD_OPEN (default 0x01) into CMD_REG.
- R6: Bring-up polling.
  - After the open command, status reads of STATUS_REG repeat, each issued 1 cycle after the previous `req_done`, until one returns ST_INIT (default 0x13).
  - The block then writes CMD_LISTEN (default 0x02) to CMD_REG.
  - Status reads then repeat the same way until one returns ST_LISTEN (default 0x14).
- R7: `link_ready` is 0 during reset and throughout bring-up. It is never 1 while `ctrl_rst_n` is low.
- R8: Supervision polling.
  - Each supervision status read is issued POLL_CYC+1 cycles after the `req_done` of the previous status read.
  - A result of ST_EST (default 0x17) sets `link_ready` in the cycle after `req_done`.
  - A result of ST_LISTEN clears `link_ready` in the cycle after `req_done`.
- R9: Any other supervision result leaves `link_ready` unchanged and causes one re-read, issued 1 cycle after `req_done`.
- R10: If the re-read is neither ST_EST nor ST_LISTEN, `link_ready` goes to 0 and `ctrl_rst_n` goes low in the cycle after `req_done`. The full sequence of R1 to R6 then repeats.
- R11: Request handshake.
  - `req_valid` is a one-cycle pulse.
  - No new request is issued until `req_done` has answered the previous one.
  - `req_write` is 1 for writes and 0 for reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_rst_n | output | 1 | Active-low reset pin of the controller |
| req_valid | output | 1 | One-cycle request strobe |
| req_write | output | 1 | 1 = register write, 0 = register read |
| req_addr | output | AW | Controller register address |
| req_wdata | output | 8 | Write data |
| req_done | input | 1 | Request completed (one cycle) |
| req_rdata | input | 8 | Read data, valid with req_done |
| link_ready | output | 1 | Socket holds an established connection |

## Verification
All outputs are registered. A request therefore appears one cycle after the state that issues it, and a decision on a read result shows on `link_ready` or `ctrl_rst_n` in the cycle after `req_done`.

The bench measures every interval from the clock edge at which `req_done` was sampled:
- a back-to-back poll or a re-read arrives after 1 cycle;
- a supervision poll arrives after POLL_CYC+1 cycles;
- the first request arrives SETTLE_CYC+1 cycles after `ctrl_rst_n` rises;
- `ctrl_rst_n` stays low for exactly RST_LOW_CYC cycles.

The bench samples `link_ready` and `ctrl_rst_n` at the falling edge right after `req_done` is removed, which is the first point where a registered result can be seen.

// File: rtl/elk_pkg.sv
package elk_pkg;

  typedef enum logic [3:0] {
    ELK_RLOW,
    ELK_SETTLE,
    ELK_CFG,
    ELK_CFG_W,
    ELK_OPEN_RD,
    ELK_OPEN_W,
    ELK_LSN_CMD,
    ELK_LSN_CW,
    ELK_LSN_RD,
    ELK_LSN_W,
    ELK_IDLE,
    ELK_SUP_RD,
    ELK_SUP_W,
    ELK_SUP_RD2,
    ELK_SUP_W2
  } elk_state_t;

  localparam int ELK_CFG_STEPS = 24;

endpackage

// File: rtl/elk_delay.sv
// Loadable down counter; zero flags the end of a wait.
module elk_delay #(
  parameter int TW      = 8,
  parameter int RST_VAL = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          zero
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= TW'(RST_VAL);
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/elk_cfg_rom.sv
// Configuration write list, computed from the parameters.
module elk_cfg_rom #(
  parameter int          AW            = 16,
  parameter logic [47:0] MAC_ID        = 48'h0,
  parameter logic [31:0] IP_ID         = 32'h0,
  parameter logic [31:0] MASK_ID       = 32'h0,
  parameter logic [31:0] GW_ID         = 32'h0,
  parameter int          MAC_REG       = 0,
  parameter int          IP_REG        = 0,
  parameter int          MASK_REG      = 0,
  parameter int          GW_REG        = 0,
  parameter int          RXMEM_REG     = 0,
  parameter int          TXMEM_REG     = 0,
  parameter int          SMODE_REG     = 0,
  parameter int          PORT_REG      = 0,
  parameter int          CMD_REG       = 0,
  parameter logic [7:0]  MEM_SPLIT     = 8'h0,
  parameter logic [7:0]  SOCK_MODE_TCP = 8'h0,
  parameter logic [15:0] LISTEN_PORT   = 16'h0,
  parameter logic [7:0]  CMD_OPEN      = 8'h0
) (
  input  logic [4:0]    step,
  output logic [AW-1:0] addr,
  output logic [7:0]    data,
  output logic          last
);
  int s;

  always_comb begin
    s    = int'(step);
    addr = '0;
    data = '0;
    if (s < 6) begin
      addr = AW'(MAC_REG + s);
      data = 8'(MAC_ID >> (8 * (5 - s)));
    end else if (s < 10) begin
      addr = AW'(IP_REG + s - 6);
      data = 8'(IP_ID >> (8 * (9 - s)));
    end else if (s < 14) begin
      addr = AW'(MASK_REG + s - 10);
      data = 8'(MASK_ID >> (8 * (13 - s)));
    end else if (s < 18) begin
      addr = AW'(GW_REG + s - 14);
      data = 8'(GW_ID >> (8 * (17 - s)));
    end else if (s == 18) begin
      addr = AW'(RXMEM_REG); data = MEM_SPLIT;
    end else if (s == 19) begin
      addr = AW'(TXMEM_REG); data = MEM_SPLIT;
    end else if (s == 20) begin
      addr = AW'(SMODE_REG); data = SOCK_MODE_TCP;
    end else if (s == 21) begin
      addr = AW'(PORT_REG);  data = LISTEN_PORT[15:8];
    end else if (s == 22) begin
      addr = AW'(PORT_REG + 1); data = LISTEN_PORT[7:0];
    end else begin
      addr = AW'(CMD_REG);   data = CMD_OPEN;
    end
    last = (s >= elk_pkg::ELK_CFG_STEPS - 1);
  end
endmodule

// File: rtl/eth_link_keeper.sv
module eth_link_keeper #(
  parameter int          AW            = 16,
  parameter int          CLK_HZ        = 50_000_000,
  parameter int          POLL_CYC      = 1_000_000,
  parameter logic [47:0] MAC_ID        = 48'h02_00_5E_10_20_30,
  parameter logic [31:0] IP_ID         = 32'hC0_A8_0A_32,
  parameter logic [31:0] MASK_ID       = 32'hFF_FF_FF_00,
  parameter logic [31:0] GW_ID         = 32'hC0_A8_0A_01,
  parameter int          GW_REG        = 'h0001,
  parameter int          MASK_REG      = 'h0005,
  parameter int          MAC_REG       = 'h0009,
  parameter int          IP_REG        = 'h000F,
  parameter int          RXMEM_REG     = 'h001A,
  parameter int          TXMEM_REG     = 'h001B,
  parameter int          SMODE_REG     = 'h0400,
  parameter int          CMD_REG       = 'h0401,
  parameter int          STATUS_REG    = 'h0403,
  parameter int          PORT_REG      = 'h0404,
  parameter logic [7:0]  MEM_SPLIT     = 8'h0A,
  parameter logic [7:0]  SOCK_MODE_TCP = 8'h01,
  parameter logic [15:0] LISTEN_PORT   = 16'd5000,
  parameter logic [7:0]  CMD_OPEN      = 8'h01,
  parameter logic [7:0]  CMD_LISTEN    = 8'h02,
  parameter logic [7:0]  ST_INIT       = 8'h13,
  parameter logic [7:0]  ST_LISTEN     = 8'h14,
  parameter logic [7:0]  ST_EST        = 8'h17
) (
  input  logic          clk,
  input  logic          rst,
  output logic          ctrl_rst_n,
  output logic          req_valid,
  output logic          req_write,
  output logic [AW-1:0] req_addr,
  output logic [7:0]    req_wdata,
  input  logic          req_done,
  input  logic [7:0]    req_rdata,
  output logic          link_ready
);
  import elk_pkg::*;

  localparam int RST_LOW_CYC = (CLK_HZ / 20 > 0) ? CLK_HZ / 20 : 1;
  localparam int SETTLE_CYC  = (CLK_HZ / 200 > 0) ? CLK_HZ / 200 : 1;
  localparam int POLL_C      = (POLL_CYC > 0) ? POLL_CYC : 1;
  localparam int MAXC        = (RST_LOW_CYC > POLL_C) ? RST_LOW_CYC : POLL_C;
  localparam int TW          = $clog2(MAXC + 1);

  elk_state_t    state;
  logic [4:0]    step;
  logic          tmr_load, tmr_zero;
  logic [TW-1:0] tmr_val;
  logic [AW-1:0] rom_addr;
  logic [7:0]    rom_data;
  logic          rom_last;
  logic          is_est, is_lsn, sup_ok;

  assign is_est = (req_rdata == ST_EST);
  assign is_lsn = (req_rdata == ST_LISTEN);
  assign sup_ok = is_est || is_lsn;

  elk_delay #(.TW(TW), .RST_VAL(RST_LOW_CYC - 1)) u_delay (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  elk_cfg_rom #(
    .AW(AW), .MAC_ID(MAC_ID), .IP_ID(IP_ID), .MASK_ID(MASK_ID), .GW_ID(GW_ID),
    .MAC_REG(MAC_REG), .IP_REG(IP_REG), .MASK_REG(MASK_REG), .GW_REG(GW_REG),
    .RXMEM_REG(RXMEM_REG), .TXMEM_REG(TXMEM_REG), .SMODE_REG(SMODE_REG),
    .PORT_REG(PORT_REG), .CMD_REG(CMD_REG), .MEM_SPLIT(MEM_SPLIT),
    .SOCK_MODE_TCP(SOCK_MODE_TCP), .LISTEN_PORT(LISTEN_PORT), .CMD_OPEN(CMD_OPEN)
  ) u_rom (
    .step(step), .addr(rom_addr), .data(rom_data), .last(rom_last)
  );

  // Timer reloads on entry to each timed state.
  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state)
      ELK_RLOW:  if (tmr_zero) begin tmr_load = 1'b1; tmr_val = TW'(SETTLE_CYC - 1); end
      ELK_LSN_W: if (req_done && is_lsn) begin tmr_load = 1'b1; tmr_val = TW'(POLL_C - 1); end
      ELK_SUP_W: if (req_done && sup_ok) begin tmr_load = 1'b1; tmr_val = TW'(POLL_C - 1); end
      ELK_SUP_W2: if (req_done) begin
        tmr_load = 1'b1;
        tmr_val  = sup_ok ? TW'(POLL_C - 1) : TW'(RST_LOW_CYC - 1);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ELK_RLOW;
      ctrl_rst_n <= 1'b0;
      req_valid  <= 1'b0;
      req_write  <= 1'b0;
      req_addr   <= '0;
      req_wdata  <= '0;
      link_ready <= 1'b0;
      step       <= '0;
    end else begin
      req_valid <= 1'b0;
      unique case (state)
        ELK_RLOW: if (tmr_zero) begin ctrl_rst_n <= 1'b1; state <= ELK_SETTLE; end
        ELK_SETTLE: if (tmr_zero) begin step <= '0; state <= ELK_CFG; end
        ELK_CFG: begin
          req_valid <= 1'b1; req_write <= 1'b1;
          req_addr  <= rom_addr; req_wdata <= rom_data;
          state     <= ELK_CFG_W;
        end
        ELK_CFG_W: if (req_done) begin
          if (rom_last) state <= ELK_OPEN_RD;
          else begin step <= step + 1'b1; state <= ELK_CFG; end
        end
        ELK_OPEN_RD, ELK_LSN_RD, ELK_SUP_RD, ELK_SUP_RD2: begin
          req_valid <= 1'b1; req_write <= 1'b0;
          req_addr  <= AW'(STATUS_REG); req_wdata <= '0;
          state     <= elk_state_t'(state + 1'b1);
        end
        ELK_OPEN_W: if (req_done) state <= (req_rdata == ST_INIT) ? ELK_LSN_CMD : ELK_OPEN_RD;
        ELK_LSN_CMD: begin
          req_valid <= 1'b1; req_write <= 1'b1;
          req_addr  <= AW'(CMD_REG); req_wdata <= CMD_LISTEN;
          state     <= ELK_LSN_CW;
        end
        ELK_LSN_CW: if (req_done) state <= ELK_LSN_RD;
        ELK_LSN_W: if (req_done) state <= is_lsn ? ELK_IDLE : ELK_LSN_RD;
        ELK_IDLE: if (tmr_zero) state <= ELK_SUP_RD;
        ELK_SUP_W: if (req_done) begin
          if (sup_ok) begin link_ready <= is_est; state <= ELK_IDLE; end
          else state <= ELK_SUP_RD2;
        end
        ELK_SUP_W2: if (req_done) begin
          if (sup_ok) begin link_ready <= is_est; state <= ELK_IDLE; end
          else begin
            link_ready <= 1'b0;
            ctrl_rst_n <= 1'b0;
            state      <= ELK_RLOW;
          end
        end
        default: state <= ELK_RLOW;
      endcase
    end
  end
endmodule

// File: rtl/elk_checker.sv
module elk_checker #(
  parameter logic [7:0] ST_EST = 8'h17
) (
  input logic       clk,
  input logic       rst,
  input logic       ctrl_rst_n,
  input logic       req_valid,
  input logic       req_done,
  input logic [7:0] req_rdata,
  input logic       link_ready
);
  logic pending;

  always_ff @(posedge clk) begin
    if (rst)            pending <= 1'b0;
    else if (req_valid) pending <= 1'b1;
    else if (req_done)  pending <= 1'b0;
  end

  assert_no_req_in_reset_R1: assert property (@(posedge clk) disable iff (rst)
    !ctrl_rst_n |-> !req_valid);

  assert_ready_needs_link_R7: assert property (@(posedge clk) disable iff (rst)
    link_ready |-> ctrl_rst_n);

  assert_ready_source_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(link_ready) |-> $past(req_done && (req_rdata == ST_EST)));

  assert_drop_on_recover_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(ctrl_rst_n) |-> !link_ready);

  assert_single_outstanding_R11: assert property (@(posedge clk) disable iff (rst)
    !(pending && req_valid));

  assert_strobe_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> !req_valid);
endmodule

bind eth_link_keeper elk_checker #(.ST_EST(ST_EST)) u_elk_checker (
  .clk(clk), .rst(rst), .ctrl_rst_n(ctrl_rst_n), .req_valid(req_valid),
  .req_done(req_done), .req_rdata(req_rdata), .link_ready(link_ready)
);

// File: tb/eth_link_keeper_tb_top.sv
`timescale 1ns/1ps
module eth_link_keeper_tb_top;
  localparam int          CLK_HZ = 2000;
  localparam int          POLL   = 20;
  localparam int          RLOW   = CLK_HZ / 20;
  localparam int          SETL   = CLK_HZ / 200;
  localparam int          LAT    = 3;
  localparam logic [47:0] MAC    = 48'hA1_B2_C3_D4_E5_F6;
  localparam logic [31:0] IPA    = 32'h0A_00_00_07;
  localparam logic [31:0] MSK    = 32'hFF_FF_F0_00;
  localparam logic [31:0] GWA    = 32'h0A_00_00_01;
  localparam int          NREADS = 15;

  logic clk = 0, rst = 1;
  logic ctrl_rst_n, req_valid, req_write, req_done, link_ready;
  logic [15:0] req_addr;
  logic [7:0]  req_wdata, req_rdata;

  always #2 clk = ~clk;

  eth_link_keeper #(
    .CLK_HZ(CLK_HZ), .POLL_CYC(POLL),
    .MAC_ID(MAC), .IP_ID(IPA), .MASK_ID(MSK), .GW_ID(GWA)
  ) dut_i (
    .clk(clk), .rst(rst), .ctrl_rst_n(ctrl_rst_n), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_done(req_done), .req_rdata(req_rdata), .link_ready(link_ready)
  );

  int checks = 0, errors = 0, cyc = 0;
  int nr = 0, nw = 0, last_done = 0;
  logic [15:0] wl_addr [0:63];
  logic [7:0]  wl_data [0:63];
  int          wl_rd   [0:63];
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] scr_val(input int i);
    case (i)
      0, 1: return 8'h00;
      2, 3, 12: return 8'h13;
      4, 6, 13: return 8'h14;
      8, 10, 11: return 8'h05;
      default: return 8'h17;
    endcase
  endfunction

  function automatic bit scr_rdy(input int i);
    return (i >= 5 && i <= 10 && i != 6) || i == 14;
  endfunction

  function automatic bit scr_rstn(input int i);
    return i != 11;
  endfunction

  function automatic int exp_addr(input int k);
    if (k < 6)  return 'h0009 + k;
    if (k < 10) return 'h000F + k - 6;
    if (k < 14) return 'h0005 + k - 10;
    if (k < 18) return 'h0001 + k - 14;
    case (k)
      18: return 'h001A;
      19: return 'h001B;
      20: return 'h0400;
      21: return 'h0404;
      22: return 'h0405;
      default: return 'h0401;
    endcase
  endfunction

  function automatic int exp_data(input int k);
    if (k < 6)  return (MAC >> (8 * (5 - k))) & 8'hFF;
    if (k < 10) return (IPA >> (8 * (9 - k))) & 8'hFF;
    if (k < 14) return (MSK >> (8 * (13 - k))) & 8'hFF;
    if (k < 18) return (GWA >> (8 * (17 - k))) & 8'hFF;
    case (k)
      18, 19: return 8'h0A;
      20: return 8'h01;
      21: return 8'h13;
      22: return 8'h88;
      23: return 8'h01;
      default: return 8'h02;
    endcase
  endfunction

  always @(posedge clk) cyc++;

  // Responder: one request at a time, LAT cycles to answer.
  initial begin
    req_done = 0; req_rdata = 0;
    forever begin
      @(negedge clk);
      if (req_valid && !rst) begin
        bit is_rd;
        int idx, gap;
        logic [7:0] v;
        is_rd = !req_write;
        idx = nr;
        v = 8'h00;
        if (req_write) begin
          if (nw < 64) begin
            wl_addr[nw] = req_addr; wl_data[nw] = req_wdata; wl_rd[nw] = nr;
          end
          nw++;
        end else begin
          gap = cyc - last_done;
          chk(req_addr == 16'h0403, "R6 status address", req_addr, 16'h0403);
          if (idx == 1 || idx == 2 || idx == 4 || idx == 13)
            chk(gap == 1, "R6 back-to-back poll", gap, 1);
          if (idx == 5 || idx == 6 || idx == 7 || idx == 8 || idx == 10 || idx == 14)
            chk(gap == POLL + 1, "R8 poll interval", gap, POLL + 1);
          if (idx == 9 || idx == 11)
            chk(gap == 1, "R9 immediate re-read", gap, 1);
          v = scr_val(idx);
        end
        repeat (LAT) begin
          @(negedge clk);
          chk(!req_valid, "R11 single outstanding", req_valid, 0);
        end
        req_done = 1; req_rdata = v;
        @(negedge clk);
        req_done = 0; req_rdata = 0;
        last_done = cyc;
        if (is_rd) begin
          chk(link_ready == scr_rdy(idx), "R7/R8/R9/R10 link_ready", link_ready, scr_rdy(idx));
          chk(ctrl_rst_n == scr_rstn(idx), "R10 controller reset", ctrl_rst_n, scr_rstn(idx));
          nr++;
        end
      end
    end
  end

  // Reset pulse width and settle delay monitor.
  int lowcnt = 0, hicnt = 0;
  bit waitfirst = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (!ctrl_rst_n) begin
        chk(!req_valid, "R1 no request in reset", req_valid, 0);
        chk(!link_ready, "R7 ready low in reset", link_ready, 0);
        lowcnt++;
      end else begin
        if (lowcnt > 0) begin
          chk(lowcnt == RLOW, "R1 reset pulse width", lowcnt, RLOW);
          lowcnt = 0; waitfirst = 1; hicnt = 1;
        end else if (waitfirst) begin
          if (req_valid) begin
            chk(hicnt == SETL + 1, "R2 settle delay", hicnt, SETL + 1);
            waitfirst = 0;
          end else hicnt++;
        end
      end
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    chk(ctrl_rst_n == 0, "R1 reset state ctrl_rst_n", ctrl_rst_n, 0);
    chk(req_valid == 0, "R11 reset state req_valid", req_valid, 0);
    chk(link_ready == 0, "R7 reset state link_ready", link_ready, 0);
    rst = 0;
    wait (nr >= NREADS);
    repeat (5) @(negedge clk);
    chk(nw == 50, "R10 two full bring-ups write count", nw, 50);
    for (int w = 0; w < 50 && w < nw; w++) begin
      int k;
      string tag;
      k = w % 25;
      tag = (k < 18) ? "R3 identity write" : (k < 21) ? "R4 memory/mode write" :
            (k < 24) ? "R5 port/open write" : "R6 listen command";
      chk(wl_addr[w] == 16'(exp_addr(k)), tag, wl_addr[w], exp_addr(k));
      chk(wl_data[w] == 8'(exp_data(k)), tag, wl_data[w], exp_data(k));
      if (k == 24)
        chk(wl_rd[w] == ((w < 25) ? 3 : 13), "R6 listen after init seen", wl_rd[w], (w < 25) ? 3 : 13);
      else if (k == 0)
        chk(wl_rd[w] == ((w < 25) ? 0 : 12), "R6 no poll before config", wl_rd[w], (w < 25) ? 0 : 12);
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d reads expected %0d", nr, NREADS);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule